// File: doc/BRIEF.md
# Manchester Receive Decoder with Sync Detection

This block recovers characters from a Manchester-coded serial input. The system clock runs at sixteen times the bit rate, so every clock cycle is one sample tick, a bit period lasts 16 ticks, and each half of a bit lasts 8 ticks. While idle, the receiver waits for the line to go low. When it finds a low, it aligns its bit grid to that low. It then walks through an optional preamble and a start frame delimiter, comparing each half-bit sample with the level it expects. If any comparison fails, the attempt is dropped and the receiver waits for the line to go high and fall again. Once the delimiter is accepted, eight data bits are decoded without moving the bit grid.

A mode input selects the delimiter. In single-bit mode the delimiter is one encoded zero. In sync mode it is a three-bit-period shape:
- a command sync is the line high for 1.5 bit periods, then low for 1.5 bit periods;
- a data sync is the inverse.

Each decoded byte is presented for one cycle together with a flag that gives the sync type. A data bit whose two halves are equal is a coding violation. It sets a sticky error flag, which a one-cycle status-reset pulse clears. An interrupt output follows the error flag, gated by two mask inputs.

Top module: `manchester_rx`

## Requirements
- R1: While idle and armed, a line low for 4 consecutive ticks (one quarter bit period) starts a reception, and the first of those low ticks becomes a half-bit boundary. A shorter low pulse starts nothing. After a reception ends or is dropped, the line must be sampled high before a new start is accepted.
- R2: With `sfdOneBit` = 1, the delimiter is a single encoded zero: a low half followed by a high half. Bytes received in this mode report `rxCmdSync` = 0.
- R3: With `sfdOneBit` = 0, the delimiter is a sync. A data sync (low 1.5 bit periods, then high 1.5) reports `rxCmdSync` = 0. A command sync (high 1.5 bit periods, then low 1.5) reports `rxCmdSync` = 1. A command sync is only recognisable when `preLen` is at least 1, because with no preamble its leading high cannot be told apart from idle.
- R4: `preLen` sets the number of preamble bit periods, and 0 skips the preamble. `preType` selects the pattern: 0 = all ones, 1 = all zeros, 2 = alternating starting with 1, 3 = alternating starting with 0.
- R5: A mismatching half in the preamble or the delimiter drops the attempt. No byte is presented and the error flag is not touched. A later well-formed frame is then decoded normally.
- R6: A data 1 is high then low within its bit period, and a data 0 is low then high. Eight data bits arrive LSB first. `rxValid` pulses for exactly one cycle, with `rxData` and `rxCmdSync` valid in that cycle.
- R7: A data bit whose two halves are sampled at the same level sets `manErr`. The bit is taken as the level of its first half, and the byte is still presented.
- R8: `manErr` stays set until a one-cycle `rstStatus` pulse clears it. If a new violation occurs in the same cycle as the pulse, the flag stays set.
- R9: `irq` is high exactly when `manErr` is set and at least one of `maskA` or `maskB` is 1.
- R10: After reset, `rxValid`, `manErr` and `irq` are 0 and `rxData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 16 ticks per bit period |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Manchester-coded serial input, high when idle |
| sfdOneBit | input | 1 | 1: delimiter is one encoded zero; 0: data or command sync |
| preLen | input | PLW | Preamble length in bit periods (0 = none) |
| preType | input | 2 | Preamble pattern selector |
| rstStatus | input | 1 | One-cycle pulse that clears the error flag |
| maskA | input | 1 | Interrupt enable for the error flag |
| maskB | input | 1 | Second interrupt enable for the error flag |
| rxData | output | DATA_W | Last decoded byte |
| rxCmdSync | output | 1 | Sync type of the last byte: 1 = command, 0 = data or single-bit |
| rxValid | output | 1 | One-cycle strobe for a new byte |
| manErr | output | 1 | Sticky coding-violation flag |
| irq | output | 1 | Masked error interrupt |

## Verification
The assertions assume that `rxLine` is already synchronous to `clk`, and that `sfdOneBit`, `preLen` and `preType` change only while no frame is in flight. They also assume `rstStatus` is a single-cycle pulse. The stimulus drives every input on falling clock edges and holds each half-bit level for a full 8 ticks. It changes modes only during idle-high gaps of several half periods between frames, and it pairs command syncs only with non-zero preambles. Under these conditions each half-bit sample lands near the middle of its half, so the presented byte is fully determined by the waveform the bench builds.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

  typedef enum logic [1:0] {
    PRE_ONES  = 2'd0,
    PRE_ZEROS = 2'd1,
    PRE_ALT10 = 2'd2,
    PRE_ALT01 = 2'd3
  } mrx_pre_e;

  // Strobes from control to datapath, all qualified by a half-bit sample.
  typedef struct packed {
    logic capH1;     // store first half of a data bit
    logic shiftBit;  // second half: shift bit in, check for violation
    logic done;      // last data half sampled
    logic setSync;   // delimiter accepted
    logic syncVal;   // sync type to record with setSync
  } mrx_strb_t;

endpackage

// File: rtl/mrx_ctrl.sv
module mrx_ctrl
  import mrx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8,
  parameter int PLW    = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           rxLine,
  input  logic           sfdOneBit,
  input  logic [PLW-1:0] preLen,
  input  logic [1:0]     preType,
  output mrx_strb_t      strb
);

  localparam int HALF = OVS / 2;
  localparam int QTR  = OVS / 4;
  localparam int TW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int QW   = $clog2(QTR + 1);
  localparam int DHW  = $clog2(2 * DATA_W) + 1;
  localparam int HIW  = (PLW + 1 > DHW) ? PLW + 1 : DHW;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_SFD, ST_DATA} state_e;

  state_e          state;
  logic            armed;
  logic [QW-1:0]   lowCnt;
  logic [TW-1:0]   tickCnt;
  logic [HIW-1:0]  halfIdx;
  logic            sType;

  logic            sampleNow;
  logic            preBit;
  logic            expHalf;
  logic            sfdOk;
  logic            sfdLast;
  logic            startLead;
  logic [HIW-1:0]  preLast;

  assign sampleNow = (state != ST_IDLE) && (tickCnt == '0);
  assign preLast   = HIW'({preLen, 1'b0}) - HIW'(1);
  assign startLead = (preLen != '0) &&
                     ((preType == PRE_ONES) || (preType == PRE_ALT10));
  assign sfdLast   = sfdOneBit ? (halfIdx == HIW'(1)) : (halfIdx == HIW'(5));

  always_comb begin
    unique case (preType)
      PRE_ONES:  preBit = 1'b1;
      PRE_ZEROS: preBit = 1'b0;
      PRE_ALT10: preBit = ~halfIdx[1];
      default:   preBit = halfIdx[1];
    endcase
    expHalf = halfIdx[0] ? ~preBit : preBit;

    if (sfdOneBit)              sfdOk = (rxLine == halfIdx[0]);
    else if (halfIdx == '0)     sfdOk = 1'b1;
    else if (halfIdx < HIW'(3)) sfdOk = (rxLine == sType);
    else                        sfdOk = (rxLine != sType);
  end

  always_comb begin
    strb          = '0;
    strb.capH1    = sampleNow && (state == ST_DATA) && !halfIdx[0];
    strb.shiftBit = sampleNow && (state == ST_DATA) && halfIdx[0];
    strb.done     = strb.shiftBit && (halfIdx == HIW'(2 * DATA_W - 1));
    strb.setSync  = sampleNow && (state == ST_SFD) && sfdOk && sfdLast;
    strb.syncVal  = sfdOneBit ? 1'b0 : sType;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      armed   <= 1'b0;
      lowCnt  <= '0;
      tickCnt <= '0;
      halfIdx <= '0;
      sType   <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (rxLine) begin
        armed  <= 1'b1;
        lowCnt <= '0;
      end else if (armed) begin
        if (lowCnt == QW'(QTR - 1)) begin
          armed   <= 1'b0;
          lowCnt  <= '0;
          tickCnt <= '0;
          if (preLen != '0) begin
            state   <= ST_PRE;
            halfIdx <= startLead ? HIW'(1) : '0;
          end else begin
            state   <= ST_SFD;
            halfIdx <= '0;
          end
        end else begin
          lowCnt <= lowCnt + QW'(1);
        end
      end
    end else begin
      tickCnt <= sampleNow ? TW'(HALF - 1) : tickCnt - TW'(1);
      if (sampleNow) begin
        unique case (state)
          ST_PRE: begin
            if (rxLine != expHalf) state <= ST_IDLE;
            else if (halfIdx == preLast) begin
              state   <= ST_SFD;
              halfIdx <= '0;
            end else halfIdx <= halfIdx + HIW'(1);
          end
          ST_SFD: begin
            if (halfIdx == '0) sType <= rxLine;
            if (!sfdOk) state <= ST_IDLE;
            else if (sfdLast) begin
              state   <= ST_DATA;
              halfIdx <= '0;
            end else halfIdx <= halfIdx + HIW'(1);
          end
          default: begin
            if (halfIdx == HIW'(2 * DATA_W - 1)) state <= ST_IDLE;
            else halfIdx <= halfIdx + HIW'(1);
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/mrx_dpath.sv
module mrx_dpath
  import mrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  mrx_strb_t         strb,
  input  logic              rstStatus,
  input  logic              maskA,
  input  logic              maskB,
  output logic [DATA_W-1:0] rxData,
  output logic              rxCmdSync,
  output logic              rxValid,
  output logic              manErr,
  output logic              irq
);

  logic              h1;
  logic              syncReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] nextShift;

  // LSB arrives first, so new bits enter at the top and move down.
  assign nextShift = {h1, shiftReg[DATA_W-1:1]};
  assign irq       = manErr && (maskA || maskB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      h1        <= 1'b0;
      syncReg   <= 1'b0;
      shiftReg  <= '0;
      rxData    <= '0;
      rxCmdSync <= 1'b0;
      rxValid   <= 1'b0;
      manErr    <= 1'b0;
    end else begin
      if (strb.capH1)    h1       <= rxLine;
      if (strb.setSync)  syncReg  <= strb.syncVal;
      if (strb.shiftBit) shiftReg <= nextShift;
      rxValid <= strb.done;
      if (strb.done) begin
        rxData    <= nextShift;
        rxCmdSync <= syncReg;
      end
      if (strb.shiftBit && (rxLine == h1)) manErr <= 1'b1;
      else if (rstStatus)                  manErr <= 1'b0;
    end
  end

endmodule

// File: rtl/manchester_rx.sv
module manchester_rx
  import mrx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8,
  parameter int PLW    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              sfdOneBit,
  input  logic [PLW-1:0]    preLen,
  input  logic [1:0]        preType,
  input  logic              rstStatus,
  input  logic              maskA,
  input  logic              maskB,
  output logic [DATA_W-1:0] rxData,
  output logic              rxCmdSync,
  output logic              rxValid,
  output logic              manErr,
  output logic              irq
);

  mrx_strb_t strb;

  mrx_ctrl #(.OVS(OVS), .DATA_W(DATA_W), .PLW(PLW)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxLine    (rxLine),
    .sfdOneBit (sfdOneBit),
    .preLen    (preLen),
    .preType   (preType),
    .strb      (strb)
  );

  mrx_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .rxLine    (rxLine),
    .strb      (strb),
    .rstStatus (rstStatus),
    .maskA     (maskA),
    .maskB     (maskB),
    .rxData    (rxData),
    .rxCmdSync (rxCmdSync),
    .rxValid   (rxValid),
    .manErr    (manErr),
    .irq       (irq)
  );

endmodule

// File: rtl/mrx_checker.sv
module mrx_checker (
  input logic clk,
  input logic rstN,
  input logic rxValid,
  input logic manErr,
  input logic irq,
  input logic maskA,
  input logic maskB,
  input logic rstStatus,
  input logic shiftStrb,
  input logic doneStrb
);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);                                   // R6
  AST_VALID_FROM_DONE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(doneStrb));                            // R6
  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(manErr) |-> $past(shiftStrb));                     // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    manErr && !rstStatus |=> manErr);                        // R8
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    rstStatus && !shiftStrb |=> !manErr);                    // R8
  AST_IRQ_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> manErr);                                         // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !maskA && !maskB |-> !irq);                              // R9

endmodule

bind manchester_rx mrx_checker i_mrx_checker (
  .clk       (clk),
  .rstN      (rstN),
  .rxValid   (rxValid),
  .manErr    (manErr),
  .irq       (irq),
  .maskA     (maskA),
  .maskB     (maskB),
  .rstStatus (rstStatus),
  .shiftStrb (strb.shiftBit),
  .doneStrb  (strb.done)
);

// File: tb/test_manchester_rx.sv
module test_manchester_rx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       sfdOneBit = 1'b1;
  logic [3:0] preLen = '0;
  logic [1:0] preType = '0;
  logic       rstStatus = 1'b0;
  logic       maskA = 1'b0;
  logic       maskB = 1'b0;
  logic [7:0] rxData;
  logic       rxCmdSync;
  logic       rxValid;
  logic       manErr;
  logic       irq;

  int testsRun = 0;
  int testsFailed = 0;
  int vCount = 0;
  logic [7:0] capData = '0;
  logic       capCmd = 1'b0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  manchester_rx i_manchester_rx (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .sfdOneBit(sfdOneBit),
    .preLen(preLen), .preType(preType), .rstStatus(rstStatus),
    .maskA(maskA), .maskB(maskB), .rxData(rxData), .rxCmdSync(rxCmdSync),
    .rxValid(rxValid), .manErr(manErr), .irq(irq)
  );

  always @(negedge clk) begin
    if (rstN && rxValid) begin
      vCount  <= vCount + 1;
      capData <= rxData;
      capCmd  <= rxCmdSync;
    end
  end

  // fields: [15] single-bit delimiter, [14] command sync, [13:12] preamble
  // type, [11:8] preamble length, [7:0] data byte
  localparam logic [15:0] VEC [8] = '{
    16'h80A5, 16'h003C, 16'h485A, 16'h14FF,
    16'hA200, 16'h7381, 16'h987E, 16'h21C3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sendHalf(input logic v);
    rxLine = v;
    repeat (8) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    sendHalf(b);
    sendHalf(~b);
  endtask

  task automatic sendPre(input logic [1:0] pt, input logic [3:0] pl);
    for (int i = 0; i < pl; i++) begin
      case (pt)
        2'd0: sendBit(1'b1);
        2'd1: sendBit(1'b0);
        2'd2: sendBit(i[0] ? 1'b0 : 1'b1);
        default: sendBit(i[0] ? 1'b1 : 1'b0);
      endcase
    end
  endtask

  task automatic sendIdle(input int halves);
    for (int i = 0; i < halves; i++) sendHalf(1'b1);
  endtask

  task automatic sendFrame(input logic ob, input logic cmd, input logic [1:0] pt,
                           input logic [3:0] pl, input logic [7:0] d);
    sfdOneBit = ob;
    preType   = pt;
    preLen    = pl;
    sendIdle(2);
    sendPre(pt, pl);
    if (ob) sendBit(1'b0);
    else begin
      for (int i = 0; i < 3; i++) sendHalf(cmd);
      for (int i = 0; i < 3; i++) sendHalf(~cmd);
    end
    for (int i = 0; i < 8; i++) sendBit(d[i]);
    sendIdle(6);
  endtask

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 rxValid", rxValid, 0);
    chk("R10 manErr", manErr, 0);
    chk("R10 irq", irq, 0);
    chk("R10 rxData", rxData, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1: two-tick low glitch while idle must not start a reception
    rxLine = 1'b0;
    repeat (2) @(negedge clk);
    sendIdle(6);
    chk("R1 glitch ignored", vCount, 0);

    for (int k = 0; k < 8; k++) begin
      logic [15:0] v;
      v = VEC[k];
      vCount = 0;
      sendFrame(v[15], v[14], v[13:12], v[11:8], v[7:0]);
      chk(v[11:8] != 0 ? "R4 one byte per frame" : "R6 one byte per frame", vCount, 1);
      chk("R6 data", capData, v[7:0]);
      chk(v[15] ? "R2 sync flag" : "R3 sync flag", capCmd, v[15] ? 1'b0 : v[14]);
    end
    chk("R7 no error on clean frames", manErr, 0);

    // R5: preamble mismatch (all ones expected, low half where high due)
    vCount = 0;
    sfdOneBit = 1'b1; preType = 2'd0; preLen = 4'd4;
    sendIdle(2);
    sendBit(1'b1); sendBit(1'b1);
    sendHalf(1'b0); sendHalf(1'b0);
    sendIdle(6);
    chk("R5 preamble mismatch drops", vCount, 0);
    chk("R5 preamble mismatch no error", manErr, 0);
    sendFrame(1'b1, 1'b0, 2'd0, 4'd4, 8'h96);
    chk("R1 resync after mismatch", vCount, 1);
    chk("R1 resync data", capData, 8'h96);

    // R5: sync shape mismatch after a zeros preamble
    vCount = 0;
    sfdOneBit = 1'b0; preType = 2'd1; preLen = 4'd2;
    sendIdle(2);
    sendPre(2'd1, 4'd2);
    sendHalf(1'b1); sendHalf(1'b1); sendHalf(1'b0); sendHalf(1'b1);
    sendIdle(6);
    chk("R5 delimiter mismatch drops", vCount, 0);
    chk("R5 delimiter mismatch no error", manErr, 0);

    // R7: violation in data bit 1 (both halves high)
    vCount = 0;
    sfdOneBit = 1'b1; preLen = 4'd0;
    sendIdle(2);
    sendBit(1'b0);
    sendBit(1'b1);
    sendHalf(1'b1); sendHalf(1'b1);
    for (int i = 2; i < 8; i++) sendBit(1'b0);
    sendIdle(6);
    chk("R7 byte still presented", vCount, 1);
    chk("R7 bit takes first half", capData, 8'h03);
    chk("R7 error set", manErr, 1);
    chk("R9 irq masked", irq, 0);
    maskA = 1'b1;
    @(negedge clk);
    chk("R9 irq maskA", irq, 1);
    maskA = 1'b0; maskB = 1'b1;
    @(negedge clk);
    chk("R9 irq maskB", irq, 1);

    vCount = 0;
    sendFrame(1'b0, 1'b1, 2'd2, 4'd2, 8'h4D);
    chk("R8 error sticky", manErr, 1);
    chk("R3 cmd after error", capCmd, 1);
    rstStatus = 1'b1;
    @(negedge clk);
    rstStatus = 1'b0;
    @(negedge clk);
    chk("R8 error cleared", manErr, 0);
    chk("R9 irq follows clear", irq, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule